// File: doc/BRIEF.md
# Parallel BCD Fixed-Point Multiplier

This block forms the exact product of two unsigned decimal integers held in packed 8421 BCD, four bits per digit. Both operands are `DIGITS` digits wide and the result is `2*DIGITS` digits wide, so no product can overflow.

The datapath has two stages. In the first stage the multiplicand multiples 2X, 3X, 4X and 5X are built once, by BCD doubling and addition. Each multiplier digit d is then recoded as d = 5*h + l, with h in {0,1} and l in 0..4. This mixes the 8421 and 5421 digit weightings. The recoded digit picks two partial products: one from {0, X, 2X, 3X, 4X} chosen by l, and one from {0, 5X} chosen by h.

In the second stage every partial product is shifted left by its digit position. All of them are then summed in a balanced binary tree of decimal adders with carry lookahead. The tree has no carry-save layer and no code conversion between its levels. The datapath is purely combinational. A parameter can place a register on the product output for timing closure; when it is present, a reset clears that register.

Top module: `bcd_par_mul`

## Requirements
- R1: For any valid BCD operands, `product` equals the exact decimal product of `mcand` and `mplier`, written as 2*DIGITS packed BCD digits. Digit k sits in bits [4k+3:4k].
- R2: Each multiplier digit d is recoded as high part h (0 or 1) and low part l (0 to 4) with d = 5*h + l. That digit contributes l*X + 5*h*X to the sum.
- R3: The multiples 2X, 3X, 4X and 5X are DIGITS+1 digits wide and are formed without losing a carry. Multiplying by each single digit 0 to 9 gives d*X.
- R4: Every digit of every adder result and of `product` lies in 0 to 9. A decimal correction of +6 is applied whenever a digit sum exceeds 9.
- R5: The partial products of multiplier digit i are weighted by 10^i, so a multiplier with one non-zero digit at position i gives d*X*10^i.
- R6: When either operand is zero, the product is all zeros.
- R7: With REG_OUT=1, `product` changes only at a rising clock edge and shows the product of the operands present at that edge. While `rst_n` is low, `product` is zero.
- R8: All-nines times all-nines gives the largest product: 9s in the upper DIGITS-1 digits, then an 8, then DIGITS-1 zeros, then a 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| mcand | input | 4*DIGITS | Multiplicand, packed 8421 BCD |
| mplier | input | 4*DIGITS | Multiplier, packed 8421 BCD |
| product | output | 8*DIGITS | Product, packed 8421 BCD |

## Verification
Some properties are checked on every evaluation by embedded assertions:
- every adder's result digits stay in 0..9;
- each recoded digit reassembles to its source digit, with a low part no larger than 4;
- neither the multiple generator nor any tree adder produces a carry out;
- a zero operand yields a zero registered product;
- the output is zero when reset is released.

Arithmetic correctness needs the bench scenarios, because only an independent binary reference can show it. Those scenarios cover all ten multiplier digit values against several multiplicands, a single non-zero digit at each position to expose the shift weighting, the all-nines extreme, and random operands. The one-cycle output timing is shown by sampling the output just after the inputs change and before the next edge.

// File: rtl/bcd_mul_pkg.sv
package bcd_mul_pkg;

   localparam int DIG_W = 4;

   typedef logic [DIG_W-1:0] digit_t;

   // Split of one decimal digit into a five-weighted part and a remainder
   typedef struct packed {
      logic       five;
      logic [2:0] rest;
   } split_t;

   function automatic split_t split_digit(digit_t d);
      split_t s;
      s.five = (d >= 4'd5);
      s.rest = s.five ? 3'(d - 4'd5) : d[2:0];
      return s;
   endfunction

endpackage

// File: rtl/bcd_cla_add.sv
module bcd_cla_add
   import bcd_mul_pkg::*;
#(
   parameter int DIGITS = 4
) (
   input  logic [DIG_W*DIGITS-1:0] a,
   input  logic [DIG_W*DIGITS-1:0] b,
   input  logic                    cin,
   output logic [DIG_W*DIGITS-1:0] sum,
   output logic                    cout
);

   localparam int LEVELS = (DIGITS > 1) ? $clog2(DIGITS) : 0;

   if (DIGITS < 1) begin : g_bad_digits
      $error("bcd_cla_add: DIGITS must be at least 1");
   end

   always_comb begin
      logic [4:0]        raw   [DIGITS];
      logic [DIGITS-1:0] gen   [LEVELS+1];
      logic [DIGITS-1:0] prop  [LEVELS+1];
      logic [DIGITS:0]   carry;
      logic [4:0]        t;
      for (int i = 0; i < DIGITS; i++) begin
         raw[i]     = {1'b0, a[DIG_W*i +: DIG_W]} + {1'b0, b[DIG_W*i +: DIG_W]};
         gen[0][i]  = (raw[i] > 5'd9);
         prop[0][i] = (raw[i] == 5'd9);
      end
      // parallel-prefix combination of digit generate/propagate
      for (int l = 0; l < LEVELS; l++) begin
         for (int i = 0; i < DIGITS; i++) begin
            if (i >= (1 << l)) begin
               gen[l+1][i]  = gen[l][i] | (prop[l][i] & gen[l][i-(1<<l)]);
               prop[l+1][i] = prop[l][i] & prop[l][i-(1<<l)];
            end else begin
               gen[l+1][i]  = gen[l][i];
               prop[l+1][i] = prop[l][i];
            end
         end
      end
      carry[0] = cin;
      for (int i = 0; i < DIGITS; i++) begin
         carry[i+1] = gen[LEVELS][i] | (prop[LEVELS][i] & cin);
      end
      for (int i = 0; i < DIGITS; i++) begin
         t = raw[i] + {4'd0, carry[i]};
         if (t > 5'd9) t = t + 5'd6;
         sum[DIG_W*i +: DIG_W] = t[3:0];
      end
      cout = carry[DIGITS];
   end

   // R4: a correctly corrected sum never holds a non-decimal digit
   always_comb begin
      logic in_ok;
      in_ok = !$isunknown({a, b, cin});
      for (int i = 0; i < DIGITS; i++) begin
         if (a[DIG_W*i +: DIG_W] > 4'd9 || b[DIG_W*i +: DIG_W] > 4'd9) in_ok = 1'b0;
      end
      if (in_ok) begin
         for (int i = 0; i < DIGITS; i++) begin
            p_sum_digit_r4: assert (sum[DIG_W*i +: DIG_W] <= 4'd9)
               else $error("adder digit %0d out of range", i);
         end
      end
   end

endmodule

// File: rtl/bcd_multiples.sv
module bcd_multiples
   import bcd_mul_pkg::*;
#(
   parameter int DIGITS = 4
) (
   input  logic [DIG_W*DIGITS-1:0]     x,
   output logic [DIG_W*(DIGITS+1)-1:0] m1,
   output logic [DIG_W*(DIGITS+1)-1:0] m2,
   output logic [DIG_W*(DIGITS+1)-1:0] m3,
   output logic [DIG_W*(DIGITS+1)-1:0] m4,
   output logic [DIG_W*(DIGITS+1)-1:0] m5
);

   localparam int MD = DIGITS + 1;

   logic [3:0] co;

   assign m1 = {{DIG_W{1'b0}}, x};

   bcd_cla_add #(.DIGITS(MD)) u_dbl  (.a(m1), .b(m1), .cin(1'b0), .sum(m2), .cout(co[0]));
   bcd_cla_add #(.DIGITS(MD)) u_quad (.a(m2), .b(m2), .cin(1'b0), .sum(m4), .cout(co[1]));
   bcd_cla_add #(.DIGITS(MD)) u_trip (.a(m2), .b(m1), .cin(1'b0), .sum(m3), .cout(co[2]));
   bcd_cla_add #(.DIGITS(MD)) u_quin (.a(m4), .b(m1), .cin(1'b0), .sum(m5), .cout(co[3]));

   // R3: multiples up to 5X fit in DIGITS+1 digits
   always_comb begin
      if (!$isunknown(x)) begin
         p_mult_nocarry_r3: assert (co == 4'b0)
            else $error("multiple generation overflowed");
         p_mult_top_r3: assert (m5[DIG_W*DIGITS +: DIG_W] <= 4'd4)
            else $error("5X leading digit too large");
      end
   end

endmodule

// File: rtl/bcd_pp_select.sv
module bcd_pp_select
   import bcd_mul_pkg::*;
#(
   parameter int DIGITS = 4
) (
   input  digit_t                      d,
   input  logic [DIG_W*(DIGITS+1)-1:0] m1,
   input  logic [DIG_W*(DIGITS+1)-1:0] m2,
   input  logic [DIG_W*(DIGITS+1)-1:0] m3,
   input  logic [DIG_W*(DIGITS+1)-1:0] m4,
   input  logic [DIG_W*(DIGITS+1)-1:0] m5,
   output logic [DIG_W*(DIGITS+1)-1:0] pp_low,
   output logic [DIG_W*(DIGITS+1)-1:0] pp_high
);

   split_t sp;

   assign sp = split_digit(d);

   always_comb begin
      unique case (sp.rest)
         3'd1:    pp_low = m1;
         3'd2:    pp_low = m2;
         3'd3:    pp_low = m3;
         3'd4:    pp_low = m4;
         default: pp_low = '0;
      endcase
      pp_high = sp.five ? m5 : '0;
   end

   // R2: the recoded parts reassemble the source digit
   always_comb begin
      if (!$isunknown(d) && d <= 4'd9) begin
         p_recode_r2: assert ((sp.five ? 4'd5 : 4'd0) + {1'b0, sp.rest} == d && sp.rest <= 3'd4)
            else $error("recode of digit %0d broken", d);
      end
   end

endmodule

// File: rtl/bcd_par_mul.sv
module bcd_par_mul
   import bcd_mul_pkg::*;
#(
   parameter int DIGITS  = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [DIG_W*DIGITS-1:0]   mcand,
   input  logic [DIG_W*DIGITS-1:0]   mplier,
   output logic [2*DIG_W*DIGITS-1:0] product
);

   localparam int MD     = DIGITS + 1;
   localparam int MW     = DIG_W * MD;
   localparam int PD     = 2 * DIGITS;
   localparam int PW     = DIG_W * PD;
   localparam int LEAVES = 2 * DIGITS;
   localparam int SLOTS  = 1 << $clog2(LEAVES);

   if (DIGITS < 1) begin : g_bad_digits
      $error("bcd_par_mul: DIGITS must be at least 1");
   end

   logic [MW-1:0] m1, m2, m3, m4, m5;
   logic [MW-1:0] pp_low  [DIGITS];
   logic [MW-1:0] pp_high [DIGITS];
   logic [PW-1:0] node    [1:2*SLOTS-1];
   logic          tree_co [1:SLOTS-1];
   logic [PW-1:0] result;

   // stage 1: shared multiples and per-digit selection
   bcd_multiples #(.DIGITS(DIGITS)) u_mult (
      .x(mcand), .m1(m1), .m2(m2), .m3(m3), .m4(m4), .m5(m5)
   );

   for (genvar i = 0; i < DIGITS; i++) begin : g_sel
      bcd_pp_select #(.DIGITS(DIGITS)) u_sel (
         .d(mplier[DIG_W*i +: DIG_W]),
         .m1(m1), .m2(m2), .m3(m3), .m4(m4), .m5(m5),
         .pp_low(pp_low[i]), .pp_high(pp_high[i])
      );
   end

   // tree leaves: shifted partial products, padding slots tied to zero
   for (genvar k = 0; k < SLOTS; k++) begin : g_leaf
      if (k < LEAVES) begin : g_used
         if (k % 2 == 0) begin : g_lo
            assign node[SLOTS+k] = PW'(pp_low[k/2]) << (DIG_W * (k/2));
         end else begin : g_hi
            assign node[SLOTS+k] = PW'(pp_high[k/2]) << (DIG_W * (k/2));
         end
      end else begin : g_pad
         assign node[SLOTS+k] = '0;
      end
   end

   // stage 2: heap-ordered adder tree, node 1 is the root
   for (genvar n = 1; n < SLOTS; n++) begin : g_tree
      bcd_cla_add #(.DIGITS(PD)) u_add (
         .a(node[2*n]), .b(node[2*n+1]), .cin(1'b0),
         .sum(node[n]), .cout(tree_co[n])
      );
   end

   assign result = node[1];

   // R1: the product range fits, so no tree adder carries out
   always_comb begin
      if (!$isunknown({mcand, mplier})) begin
         for (int n = 1; n < SLOTS; n++) begin
            p_tree_nocarry_r1: assert (tree_co[n] == 1'b0)
               else $error("tree adder %0d carried out", n);
         end
      end
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) product <= '0;
         else        product <= result;
      end

      p_zero_operand_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (mcand == '0 || mplier == '0) |=> (product == '0))
         else $error("zero operand gave non-zero product");

      p_reset_clear_r7: assert property (@(posedge clk)
         $rose(rst_n) |-> (product == '0))
         else $error("product not cleared by reset");
   end else begin : g_comb
      assign product = result;

      always_comb begin
         if (!$isunknown({mcand, mplier}) && (mcand == '0 || mplier == '0)) begin
            p_zero_operand_r6: assert (result == '0)
               else $error("zero operand gave non-zero product");
         end
      end
   end

endmodule

// File: tb/sim_bcd_par_mul.sv
`timescale 1ns/1ps
module sim_bcd_par_mul;

   localparam int N   = 4;
   localparam int AW  = 4 * N;
   localparam int PWB = 8 * N;

   typedef struct {
      logic [PWB-1:0] exp;
      string          tag;
   } item_t;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [AW-1:0]  mc = '0;
   logic [AW-1:0]  mp = '0;
   logic [PWB-1:0] product;

   item_t sb[$];
   int    n_checks = 0;
   int    n_fail   = 0;
   bit    done     = 1'b0;

   always #2.5 clk = ~clk;

   bcd_par_mul #(.DIGITS(N), .REG_OUT(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .mcand(mc), .mplier(mp), .product(product)
   );

   function automatic longint to_bin(logic [PWB-1:0] v, int nd);
      longint r = 0;
      for (int i = nd - 1; i >= 0; i--) r = r * 10 + longint'(v[4*i +: 4]);
      return r;
   endfunction

   function automatic logic [PWB-1:0] to_bcd(longint v);
      logic [PWB-1:0] r = '0;
      for (int i = 0; i < 2 * N; i++) begin
         r[4*i +: 4] = 4'(v % 10);
         v = v / 10;
      end
      return r;
   endfunction

   function automatic logic [AW-1:0] rand_bcd();
      logic [AW-1:0] r;
      for (int i = 0; i < N; i++) r[4*i +: 4] = 4'($urandom % 10);
      return r;
   endfunction

   task automatic check(bit ok, string req, logic [PWB-1:0] act, logic [PWB-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   // driver: apply operands, queue the reference result
   task automatic apply(logic [AW-1:0] a, logic [AW-1:0] b, string tag);
      item_t it;
      @(negedge clk);
      mc = a;
      mp = b;
      @(posedge clk);
      it.exp = to_bcd(to_bin(PWB'(a), N) * to_bin(PWB'(b), N));
      it.tag = tag;
      sb.push_back(it);
   endtask

   // monitor: compare one negedge after the capturing edge
   initial begin
      forever begin
         @(negedge clk);
         while (sb.size() > 0) begin
            item_t it;
            bit    dig_ok;
            it = sb.pop_front();
            check(product === it.exp, it.tag, product, it.exp);
            dig_ok = 1'b1;
            for (int i = 0; i < 2 * N; i++) if (product[4*i +: 4] > 4'd9) dig_ok = 1'b0;
            check(dig_ok, "R4 digit range", product, it.exp);
         end
      end
   end

   initial begin
      #(5.0 * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      // R7: reset holds the product at zero with live operands
      mc = 16'h1234;
      mp = 16'h5678;
      repeat (3) @(negedge clk);
      check(product === '0, "R7 reset", product, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check(product === to_bcd(64'd1234 * 64'd5678), "R7 first edge", product,
            to_bcd(64'd1234 * 64'd5678));

      // R6: zero operands
      apply(16'h0000, 16'h9999, "R6 zero mcand");
      apply(16'h4321, 16'h0000, "R6 zero mplier");
      apply(16'h0000, 16'h0000, "R6 both zero");

      // R8: extreme
      apply(16'h9999, 16'h9999, "R8 all nines");

      // R2 and R3: every single digit against several multiplicands
      for (int d = 0; d < 10; d++) begin
         apply(16'h9999, AW'(d), "R3 d*9999");
         apply(16'h1234, AW'(d), "R2 d*1234");
         apply(16'h5087, AW'(d), "R2 d*5087");
      end

      // R5: one non-zero multiplier digit at each position
      for (int pos = 0; pos < N; pos++) begin
         for (int d = 1; d < 10; d += 4) begin
            apply(16'h9876, AW'(d) << (4 * pos), "R5 positional weight");
         end
      end

      // R7: output holds until the next rising edge
      apply(16'h2468, 16'h1357, "R7 setup");
      @(negedge clk);
      mc = 16'h9999;
      mp = 16'h0001;
      #1;
      check(product === to_bcd(64'd2468 * 64'd1357), "R7 hold before edge", product,
            to_bcd(64'd2468 * 64'd1357));
      @(posedge clk);
      #1;
      check(product === to_bcd(64'd9999), "R7 update at edge", product, to_bcd(64'd9999));

      // R1: random operands
      for (int k = 0; k < 400; k++) begin
         apply(rand_bcd(), rand_bcd(), "R1 random");
      end

      repeat (3) @(negedge clk);
      check(sb.size() == 0, "R1 scoreboard drained", PWB'(sb.size()), '0);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule